// File: doc/BRIEF.md
# Radar Frame and Chirp Timing Sequencer

This block produces the cycle-exact schedule of one radar frame from a hardware trigger pulse. The clock runs at 200 MHz, so one tick is 5 ns. When a trigger is accepted, the block waits a programmable number of ticks. It then plays out a programmable number of chirps. Each chirp passes through four sub-phases in a fixed order: synthesizer settle (idle), ADC start-up, ADC sampling window, and excess ramp. ADC enable is raised only inside the sampling window, so the non-linear start of each ramp is never sampled. After the last chirp, one cycle marks the hand-off to post-processing and signals that the frame is complete.

A free-running 48-bit tick counter runs alongside the sequencer. When a trigger is accepted, the block latches three timestamps: the trigger, the start of capture, and the middle of the exposure. Software can therefore place each frame on a common time base. The configuration inputs (four sub-phase lengths, the delay and the chirp count) are copied when a trigger is accepted. A frame in flight is never disturbed by reprogramming. A trigger that arrives while a frame is running is dropped and recorded in a sticky overrun flag.

The sequencer states are IDLE, DELAY, CH_IDLE, CH_ADCST, CH_SAMPLE, CH_RAMP and DONE. The transitions are:
- IDLE to DELAY: trigger with a non-zero delay.
- IDLE or DELAY into the first chirp sub-phase whose length is non-zero: trigger with zero delay, or the delay has run out.
- One chirp sub-phase to the next non-zero sub-phase.
- End of a chirp back to the first non-zero sub-phase: more chirps remain.
- End of the last chirp to DONE.
- IDLE or DELAY straight to DONE: every sub-phase length is zero.
- DONE to IDLE, always.

Top module: `radar_frame_seq`

## Requirements
- R1: After reset, phase_o is 0 (IDLE). adc_en_o, chirp_start_o, proc_start_o, frame_done_o and overrun_o are 0, chirp_idx_o is 0, and all three latched timestamps are 0. ts_now_o is 1 in the first cycle after reset is released.
- R2: Only trig_i starts a frame. A trigger seen in IDLE with a non-zero chirp count puts phase_o at 1 (DELAY) for exactly cfg_delay_i cycles, starting the cycle after the trigger. A delay of 0 skips DELAY entirely.
- R3: Each chirp visits CH_IDLE (2), CH_ADCST (3), CH_SAMPLE (4) and CH_RAMP (5) in this order. Each sub-phase lasts exactly its programmed number of cycles. A sub-phase of length 0 is skipped without using a cycle. The first chirp starts D+1 cycles after the trigger cycle, where D is the delay.
- R4: adc_en_o is 1 in exactly the cycles where phase_o is CH_SAMPLE.
- R5: chirp_start_o is high for one cycle, in the first cycle of every chirp. chirp_idx_o equals k throughout chirp k, counting from 0 to N-1, and is 0 outside chirps.
- R6: Let C be the sum of the four lengths and N the chirp count. After the last chirp, phase_o is 6 (DONE) for one cycle, at D+1+N*C cycles after the trigger cycle. proc_start_o and frame_done_o are both 1 in that cycle, and the next cycle is IDLE. If C is 0, DONE follows the delay directly with no chirp strobes.
- R7: A trigger with a chirp count of 0 leaves phase_o in IDLE, with no chirp, ADC or done strobes.
- R8: An accepted trigger latches three values, visible from the next cycle:
  - ts_trig_o = ts_now_o of the trigger cycle + 1
  - ts_capture_o = ts_trig_o + D
  - ts_mid_o = ts_capture_o + floor(C*N/2)

  The values hold until the next accepted trigger. ts_capture_o equals ts_now_o in the first chirp cycle.
- R9: A trigger seen while phase_o is not IDLE is ignored: it changes neither the schedule nor the timestamps. It sets overrun_o from the next cycle. overrun_o stays set until ovf_clr_i is high at a clock edge. A set and a clear in the same cycle leave the flag set.
- R10: Changing the configuration inputs while a frame runs has no effect on that frame.
- R11: ts_now_o increases by exactly 1 every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz clock, one tick = 5 ns |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Hardware frame trigger |
| ovf_clr_i | input | 1 | Clears the overrun flag |
| cfg_idle_len_i | input | 16 | Settle sub-phase length in ticks |
| cfg_adcst_len_i | input | 16 | ADC start-up sub-phase length in ticks |
| cfg_sample_len_i | input | 16 | Sampling window length in ticks |
| cfg_ramp_len_i | input | 16 | Excess ramp length in ticks |
| cfg_delay_i | input | 16 | Trigger-to-capture delay in ticks |
| cfg_nchirps_i | input | 10 | Chirps per frame |
| phase_o | output | 3 | Current state code (0 to 6) |
| adc_en_o | output | 1 | ADC sampling enable |
| chirp_start_o | output | 1 | First cycle of a chirp |
| chirp_idx_o | output | 10 | Index of the running chirp |
| proc_start_o | output | 1 | Post-processing start strobe |
| frame_done_o | output | 1 | Frame complete strobe |
| overrun_o | output | 1 | Sticky dropped-trigger flag |
| ts_now_o | output | 48 | Free-running tick count |
| ts_trig_o | output | 48 | Latched trigger timestamp |
| ts_capture_o | output | 48 | Start-of-capture timestamp |
| ts_mid_o | output | 48 | Mid-exposure timestamp |

## Verification
The hardest situations to reach come from the zero-length skip logic. Several sub-phases can be zero in the same chirp: the chirp then starts in, say, the ADC start-up phase, or jumps straight from the delay to DONE. Other hard cases are a trigger that lands exactly on the DONE cycle, and a trigger that lands in the same cycle as an overrun clear. The stimulus draws lengths from a range of 0 to 4, so zeros come up often and chains of skipped phases follow. Overrun triggers are injected at a random cycle anywhere from the first delay cycle up to and including DONE. A few directed frames pin down the all-zero, zero-count, single-tick and set-with-clear cases.

// File: rtl/radar_frame_seq_pkg.sv
package radar_frame_seq_pkg;

    // State codes are visible on phase_o; chirp sub-phases are contiguous
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DELAY     = 3'd1,
        ST_CH_IDLE   = 3'd2,
        ST_CH_ADCST  = 3'd3,
        ST_CH_SAMPLE = 3'd4,
        ST_CH_RAMP   = 3'd5,
        ST_DONE      = 3'd6
    } seq_state_e;

    localparam int NUM_SUBPH = 4;

endpackage

// File: rtl/rfs_tick_counter.sv
module rfs_tick_counter #(
    parameter int TS_W = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_o <= '0;
        end else begin
            now_o <= now_o + TS_W'(1);
        end
    end

endmodule

// File: rtl/rfs_overrun_flag.sv
module rfs_overrun_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    // A set in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/rfs_stamp_calc.sv
module rfs_stamp_calc
    import radar_frame_seq_pkg::*;
#(
    parameter int TS_W  = 48,
    parameter int LEN_W = 16,
    parameter int DLY_W = 16,
    parameter int CNT_W = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic [TS_W-1:0]                 now_i,
    input  logic [NUM_SUBPH-1:0][LEN_W-1:0] lens_i,
    input  logic [DLY_W-1:0]                delay_i,
    input  logic [CNT_W-1:0]                nchirps_i,
    output logic [TS_W-1:0]                 ts_trig_o,
    output logic [TS_W-1:0]                 ts_cap_o,
    output logic [TS_W-1:0]                 ts_mid_o
);

    localparam int CYC_W  = LEN_W + $clog2(NUM_SUBPH);
    localparam int PROD_W = CYC_W + CNT_W;

    logic [CYC_W-1:0]  cyc_len;
    logic [PROD_W-1:0] expo_ticks;
    logic [TS_W-1:0]   trig_n;
    logic [TS_W-1:0]   cap_n;
    logic [TS_W-1:0]   mid_n;

    always_comb begin
        cyc_len = '0;
        for (int i = 0; i < NUM_SUBPH; i++) begin
            cyc_len = cyc_len + CYC_W'(lens_i[i]);
        end
        expo_ticks = PROD_W'(cyc_len) * PROD_W'(nchirps_i);
        // Stamps refer to the first cycle after the trigger edge
        trig_n     = now_i + TS_W'(1);
        cap_n      = trig_n + TS_W'(delay_i);
        mid_n      = cap_n + TS_W'(expo_ticks >> 1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_trig_o <= '0;
            ts_cap_o  <= '0;
            ts_mid_o  <= '0;
        end else if (load_i) begin
            ts_trig_o <= trig_n;
            ts_cap_o  <= cap_n;
            ts_mid_o  <= mid_n;
        end
    end

endmodule

// File: rtl/rfs_frame_fsm.sv
module rfs_frame_fsm
    import radar_frame_seq_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int DLY_W = 16,
    parameter int CNT_W = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            trig_i,
    input  logic [NUM_SUBPH-1:0][LEN_W-1:0] cfg_lens_i,
    input  logic [DLY_W-1:0]                cfg_delay_i,
    input  logic [CNT_W-1:0]                cfg_nchirps_i,
    output seq_state_e                      state_o,
    output logic                            accept_o,
    output logic                            reject_o,
    output logic                            adc_en_o,
    output logic                            chirp_start_o,
    output logic [CNT_W-1:0]                chirp_idx_o,
    output logic                            proc_start_o,
    output logic                            frame_done_o
);

    localparam int CTR_W = (LEN_W > DLY_W) ? LEN_W : DLY_W;
    localparam logic [2:0] NO_PHASE = 3'(NUM_SUBPH);

    seq_state_e                      state_q, state_d;
    logic [CTR_W-1:0]                rem_q, rem_d;
    logic [CNT_W-1:0]                idx_q, idx_d;
    logic [NUM_SUBPH-1:0][LEN_W-1:0] shd_lens_q;
    logic [CNT_W-1:0]                shd_n_q;
    logic [NUM_SUBPH-1:0][LEN_W-1:0] lens_eff;
    logic [2:0]                      first_p;
    logic [2:0]                      nxt_p;
    int                              cur_p;
    logic                            go_first;
    logic                            go_sub;
    logic                            start_chirp_d;
    logic                            last_chirp;

    // Lowest sub-phase index at or above 'from' with a non-zero length
    function automatic logic [2:0] next_live(
        input logic [NUM_SUBPH-1:0][LEN_W-1:0] lens,
        input int                              from
    );
        logic [2:0] r;
        r = NO_PHASE;
        for (int i = NUM_SUBPH - 1; i >= 0; i--) begin
            if (i >= from && lens[i] != '0) begin
                r = 3'(i);
            end
        end
        return r;
    endfunction

    function automatic seq_state_e sub_state(input logic [2:0] p);
        return seq_state_e'(p + 3'(ST_CH_IDLE));
    endfunction

    assign accept_o   = trig_i && (state_q == ST_IDLE);
    assign reject_o   = trig_i && (state_q != ST_IDLE);
    assign lens_eff   = (state_q == ST_IDLE) ? cfg_lens_i : shd_lens_q;
    assign cur_p      = int'(state_q) - int'(ST_CH_IDLE);
    assign first_p    = next_live(lens_eff, 0);
    assign nxt_p      = next_live(lens_eff, cur_p + 1);
    assign last_chirp = (idx_q == shd_n_q - CNT_W'(1));

    // Next-state logic
    always_comb begin
        state_d       = state_q;
        rem_d         = rem_q;
        idx_d         = idx_q;
        go_first      = 1'b0;
        go_sub        = 1'b0;
        start_chirp_d = 1'b0;

        unique case (state_q)
            ST_IDLE: begin
                if (trig_i && cfg_nchirps_i != '0) begin
                    idx_d = '0;
                    if (cfg_delay_i != '0) begin
                        state_d = ST_DELAY;
                        rem_d   = CTR_W'(cfg_delay_i) - CTR_W'(1);
                    end else begin
                        go_first = 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (rem_q == '0) begin
                    go_first = 1'b1;
                end else begin
                    rem_d = rem_q - CTR_W'(1);
                end
            end
            ST_CH_IDLE, ST_CH_ADCST, ST_CH_SAMPLE, ST_CH_RAMP: begin
                if (rem_q != '0) begin
                    rem_d = rem_q - CTR_W'(1);
                end else if (nxt_p != NO_PHASE) begin
                    go_sub = 1'b1;
                end else if (last_chirp) begin
                    state_d = ST_DONE;
                end else begin
                    idx_d    = idx_q + CNT_W'(1);
                    go_first = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase

        if (go_first) begin
            if (first_p == NO_PHASE) begin
                state_d = ST_DONE;
            end else begin
                state_d       = sub_state(first_p);
                rem_d         = CTR_W'(lens_eff[first_p[1:0]]) - CTR_W'(1);
                start_chirp_d = 1'b1;
            end
        end
        if (go_sub) begin
            state_d = sub_state(nxt_p);
            rem_d   = CTR_W'(lens_eff[nxt_p[1:0]]) - CTR_W'(1);
        end
    end

    // State register with counters and configuration shadow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rem_q      <= '0;
            idx_q      <= '0;
            shd_lens_q <= '0;
            shd_n_q    <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            idx_q   <= idx_d;
            if (accept_o) begin
                shd_lens_q <= cfg_lens_i;
                shd_n_q    <= cfg_nchirps_i;
            end
        end
    end

    // Registered outputs, aligned with state_q
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_en_o      <= 1'b0;
            chirp_start_o <= 1'b0;
            proc_start_o  <= 1'b0;
            frame_done_o  <= 1'b0;
        end else begin
            adc_en_o      <= (state_d == ST_CH_SAMPLE);
            chirp_start_o <= start_chirp_d;
            proc_start_o  <= (state_d == ST_DONE);
            frame_done_o  <= (state_d == ST_DONE);
        end
    end

    assign chirp_idx_o = (state_q >= ST_CH_IDLE && state_q <= ST_CH_RAMP) ? idx_q : '0;
    assign state_o     = state_q;

endmodule

// File: rtl/radar_frame_seq.sv
module radar_frame_seq
    import radar_frame_seq_pkg::*;
#(
    parameter int TS_W  = 48,
    parameter int LEN_W = 16,
    parameter int DLY_W = 16,
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             ovf_clr_i,
    input  logic [LEN_W-1:0] cfg_idle_len_i,
    input  logic [LEN_W-1:0] cfg_adcst_len_i,
    input  logic [LEN_W-1:0] cfg_sample_len_i,
    input  logic [LEN_W-1:0] cfg_ramp_len_i,
    input  logic [DLY_W-1:0] cfg_delay_i,
    input  logic [CNT_W-1:0] cfg_nchirps_i,
    output logic [2:0]       phase_o,
    output logic             adc_en_o,
    output logic             chirp_start_o,
    output logic [CNT_W-1:0] chirp_idx_o,
    output logic             proc_start_o,
    output logic             frame_done_o,
    output logic             overrun_o,
    output logic [TS_W-1:0]  ts_now_o,
    output logic [TS_W-1:0]  ts_trig_o,
    output logic [TS_W-1:0]  ts_capture_o,
    output logic [TS_W-1:0]  ts_mid_o
);

    logic [NUM_SUBPH-1:0][LEN_W-1:0] cfg_lens;
    seq_state_e                      state;
    logic                            accept;
    logic                            reject;

    // Order of this array is the chirp sub-phase order
    assign cfg_lens[0] = cfg_idle_len_i;
    assign cfg_lens[1] = cfg_adcst_len_i;
    assign cfg_lens[2] = cfg_sample_len_i;
    assign cfg_lens[3] = cfg_ramp_len_i;

    rfs_tick_counter #(.TS_W(TS_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .now_o (ts_now_o)
    );

    rfs_frame_fsm #(
        .LEN_W (LEN_W),
        .DLY_W (DLY_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig_i        (trig_i),
        .cfg_lens_i    (cfg_lens),
        .cfg_delay_i   (cfg_delay_i),
        .cfg_nchirps_i (cfg_nchirps_i),
        .state_o       (state),
        .accept_o      (accept),
        .reject_o      (reject),
        .adc_en_o      (adc_en_o),
        .chirp_start_o (chirp_start_o),
        .chirp_idx_o   (chirp_idx_o),
        .proc_start_o  (proc_start_o),
        .frame_done_o  (frame_done_o)
    );

    rfs_stamp_calc #(
        .TS_W  (TS_W),
        .LEN_W (LEN_W),
        .DLY_W (DLY_W),
        .CNT_W (CNT_W)
    ) u_stamp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .now_i     (ts_now_o),
        .lens_i    (cfg_lens),
        .delay_i   (cfg_delay_i),
        .nchirps_i (cfg_nchirps_i),
        .ts_trig_o (ts_trig_o),
        .ts_cap_o  (ts_capture_o),
        .ts_mid_o  (ts_mid_o)
    );

    rfs_overrun_flag u_ovr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (reject),
        .clr_i  (ovf_clr_i),
        .flag_o (overrun_o)
    );

    assign phase_o = state;

endmodule

// File: rtl/radar_frame_seq_checker.sv
module radar_frame_seq_checker
    import radar_frame_seq_pkg::*;
#(
    parameter int TS_W  = 48,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_i,
    input logic             ovf_clr_i,
    input logic [2:0]       phase_o,
    input logic             adc_en_o,
    input logic             chirp_start_o,
    input logic [CNT_W-1:0] chirp_idx_o,
    input logic             proc_start_o,
    input logic             frame_done_o,
    input logic             overrun_o,
    input logic [TS_W-1:0]  ts_trig_o,
    input logic [TS_W-1:0]  ts_capture_o,
    input logic [TS_W-1:0]  ts_mid_o
);

    logic in_chirp;
    assign in_chirp = (phase_o >= 3'(ST_CH_IDLE)) && (phase_o <= 3'(ST_CH_RAMP));

    AST_ADC_ONLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        adc_en_o |-> phase_o == 3'(ST_CH_SAMPLE)); // R4
    AST_WINDOW_HAS_ADC: assert property (@(posedge clk) disable iff (!rst_n)
        phase_o == 3'(ST_CH_SAMPLE) |-> adc_en_o); // R4
    AST_DELAY_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 3'(ST_DELAY) && $past(phase_o) == 3'(ST_IDLE)) |-> $past(trig_i)); // R2
    AST_CHIRP_START_IN_CHIRP: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_start_o |-> in_chirp); // R5
    AST_IDX_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_chirp |-> chirp_idx_o == '0); // R5
    AST_DONE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        proc_start_o |-> (frame_done_o && phase_o == 3'(ST_DONE))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        proc_start_o |=> (!proc_start_o && phase_o == 3'(ST_IDLE))); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovf_clr_i) |=> overrun_o); // R9
    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(trig_i) && $past(phase_o) != 3'(ST_IDLE))); // R9
    AST_STAMP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_capture_o >= ts_trig_o) && (ts_mid_o >= ts_capture_o)); // R8
    AST_STAMPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 3'(ST_IDLE) && $past(phase_o) != 3'(ST_IDLE))
            |-> ($stable(ts_mid_o) && $stable(ts_trig_o))); // R9

endmodule

bind radar_frame_seq radar_frame_seq_checker #(
    .TS_W  (TS_W),
    .CNT_W (CNT_W)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_i        (trig_i),
    .ovf_clr_i     (ovf_clr_i),
    .phase_o       (phase_o),
    .adc_en_o      (adc_en_o),
    .chirp_start_o (chirp_start_o),
    .chirp_idx_o   (chirp_idx_o),
    .proc_start_o  (proc_start_o),
    .frame_done_o  (frame_done_o),
    .overrun_o     (overrun_o),
    .ts_trig_o     (ts_trig_o),
    .ts_capture_o  (ts_capture_o),
    .ts_mid_o      (ts_mid_o)
);

// File: tb/radar_frame_seq_bench.sv
module radar_frame_seq_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_i = 1'b0;
    logic        ovf_clr_i = 1'b0;
    logic [15:0] cfg_idle_len_i = '0;
    logic [15:0] cfg_adcst_len_i = '0;
    logic [15:0] cfg_sample_len_i = '0;
    logic [15:0] cfg_ramp_len_i = '0;
    logic [15:0] cfg_delay_i = '0;
    logic [9:0]  cfg_nchirps_i = '0;
    logic [2:0]  phase_o;
    logic        adc_en_o;
    logic        chirp_start_o;
    logic [9:0]  chirp_idx_o;
    logic        proc_start_o;
    logic        frame_done_o;
    logic        overrun_o;
    logic [47:0] ts_now_o;
    logic [47:0] ts_trig_o;
    logic [47:0] ts_capture_o;
    logic [47:0] ts_mid_o;

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     exp_ovr = 1'b0;
    bit     finished = 1'b0;
    longint last_now = 0;

    typedef struct {
        int ph;
        bit adc;
        bit cs;
        int idx;
        bit done;
    } exp_t;

    always #(CLK_PERIOD / 2) clk = ~clk;

    radar_frame_seq u_radar_frame_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .trig_i           (trig_i),
        .ovf_clr_i        (ovf_clr_i),
        .cfg_idle_len_i   (cfg_idle_len_i),
        .cfg_adcst_len_i  (cfg_adcst_len_i),
        .cfg_sample_len_i (cfg_sample_len_i),
        .cfg_ramp_len_i   (cfg_ramp_len_i),
        .cfg_delay_i      (cfg_delay_i),
        .cfg_nchirps_i    (cfg_nchirps_i),
        .phase_o          (phase_o),
        .adc_en_o         (adc_en_o),
        .chirp_start_o    (chirp_start_o),
        .chirp_idx_o      (chirp_idx_o),
        .proc_start_o     (proc_start_o),
        .frame_done_o     (frame_done_o),
        .overrun_o        (overrun_o),
        .ts_now_o         (ts_now_o),
        .ts_trig_o        (ts_trig_o),
        .ts_capture_o     (ts_capture_o),
        .ts_mid_o         (ts_mid_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R11", "ts_now step", longint'(ts_now_o), last_now + 1);
        last_now = longint'(ts_now_o);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Expected outputs k cycles after the trigger cycle (k = 0)
    function automatic exp_t model(int k, int l0, int l1, int l2, int l3, int dly, int n);
        exp_t e;
        int   c;
        int   j;
        int   r;
        e.ph = 0; e.adc = 0; e.cs = 0; e.idx = 0; e.done = 0;
        c = l0 + l1 + l2 + l3;
        if (n == 0 || k <= 0) return e;
        if (k <= dly) begin
            e.ph = 1;
            return e;
        end
        j = k - dly - 1;
        if (j < n * c) begin
            e.idx = j / c;
            r     = j % c;
            e.cs  = (r == 0);
            if (r < l0)                e.ph = 2;
            else if (r < l0 + l1)      e.ph = 3;
            else if (r < l0 + l1 + l2) begin e.ph = 4; e.adc = 1; end
            else                       e.ph = 5;
        end else if (j == n * c) begin
            e.ph   = 6;
            e.done = 1;
        end
        return e;
    endfunction

    task automatic run_frame(int l0, int l1, int l2, int l3, int dly, int n,
                             int inj_k, int clr_k, int scr_k);
        int     c;
        int     last_k;
        longint t0;
        longint e_cap;
        longint e_mid;
        exp_t   e;
        string  req;
        c      = l0 + l1 + l2 + l3;
        last_k = (n == 0) ? 3 : dly + n * c + 2;
        t0     = 0;
        e_cap  = 0;
        e_mid  = 0;
        for (int k = 0; k <= last_k; k++) begin
            e = model(k, l0, l1, l2, l3, dly, n);
            if (scr_k >= 0 && k > scr_k) req = "R10";
            else if (n == 0)             req = "R7";
            else if (e.ph == 1)          req = "R2";
            else if (e.ph == 6)          req = "R6";
            else                         req = "R3";
            chk(req, "phase", longint'(phase_o), e.ph);
            chk("R4", "adc_en", longint'(adc_en_o), e.adc);
            chk("R5", "chirp_start", longint'(chirp_start_o), e.cs);
            chk("R5", "chirp_idx", longint'(chirp_idx_o), e.idx);
            chk("R6", "proc_start", longint'(proc_start_o), e.done);
            chk("R6", "frame_done", longint'(frame_done_o), e.done);
            chk("R9", "overrun", longint'(overrun_o), exp_ovr);
            if (k == 0) t0 = longint'(ts_now_o);
            if (k == 1) begin
                e_cap = t0 + 1 + dly;
                e_mid = e_cap + (c * n) / 2;
                chk("R8", "ts_trig", longint'(ts_trig_o), t0 + 1);
                chk("R8", "ts_capture", longint'(ts_capture_o), e_cap);
                chk("R8", "ts_mid", longint'(ts_mid_o), e_mid);
            end
            if (n > 0 && c > 0 && k == dly + 1)
                chk("R8", "capture vs now", longint'(ts_now_o), e_cap);
            if (k == last_k) begin
                chk("R9", "ts_trig held", longint'(ts_trig_o), t0 + 1);
                chk("R9", "ts_mid held", longint'(ts_mid_o), e_mid);
            end
            // drive for the next edge
            if (k == 0) begin
                cfg_idle_len_i   = 16'(l0);
                cfg_adcst_len_i  = 16'(l1);
                cfg_sample_len_i = 16'(l2);
                cfg_ramp_len_i   = 16'(l3);
                cfg_delay_i      = 16'(dly);
                cfg_nchirps_i    = 10'(n);
            end
            if (k == scr_k) begin
                cfg_idle_len_i   = 16'($urandom_range(0, 7));
                cfg_adcst_len_i  = 16'($urandom_range(0, 7));
                cfg_sample_len_i = 16'($urandom_range(0, 7));
                cfg_ramp_len_i   = 16'($urandom_range(0, 7));
                cfg_delay_i      = 16'($urandom_range(0, 30));
                cfg_nchirps_i    = 10'($urandom_range(0, 9));
            end
            trig_i    = (k == 0) || (k == inj_k);
            ovf_clr_i = (k == clr_k);
            if (k == clr_k) exp_ovr = 1'b0;
            if (k == inj_k) exp_ovr = 1'b1;
            tick();
        end
        trig_i    = 1'b0;
        ovf_clr_i = 1'b0;
        if (exp_ovr) begin
            ovf_clr_i = 1'b1;
            tick();
            ovf_clr_i = 1'b0;
            exp_ovr   = 1'b0;
            chk("R9", "overrun cleared", longint'(overrun_o), 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "phase", longint'(phase_o), 0);
        chk("R1", "adc_en", longint'(adc_en_o), 0);
        chk("R1", "chirp_start", longint'(chirp_start_o), 0);
        chk("R1", "chirp_idx", longint'(chirp_idx_o), 0);
        chk("R1", "proc_start", longint'(proc_start_o), 0);
        chk("R1", "frame_done", longint'(frame_done_o), 0);
        chk("R1", "overrun", longint'(overrun_o), 0);
        chk("R1", "ts_trig", longint'(ts_trig_o), 0);
        chk("R1", "ts_capture", longint'(ts_capture_o), 0);
        chk("R1", "ts_mid", longint'(ts_mid_o), 0);
        chk("R1", "ts_now", longint'(ts_now_o), 1);
        last_now = longint'(ts_now_o);
        repeat (3) tick();
        chk("R2", "no trigger stays idle", longint'(phase_o), 0);

        // Directed corner cases
        run_frame(2, 3, 4, 1, 5, 3, -1, -1, -1);   // plain frame
        run_frame(1, 1, 1, 1, 0, 2, -1, -1, -1);   // zero delay (R2)
        run_frame(0, 2, 3, 0, 3, 2, -1, -1, -1);   // chirp starts in ADC start (R3, R5)
        run_frame(2, 0, 0, 2, 1, 2, -1, -1, -1);   // no sampling window (R4)
        run_frame(0, 0, 0, 0, 4, 3, -1, -1, -1);   // all lengths zero (R6)
        run_frame(3, 3, 3, 3, 2, 0, -1, -1, -1);   // zero chirp count (R7)
        run_frame(0, 0, 1, 0, 0, 1, -1, -1, -1);   // single-tick frame
        run_frame(1, 1, 1, 0, 2, 3, -1, -1, -1);   // odd exposure truncates (R8)
        run_frame(2, 1, 2, 1, 3, 2, 4, 4, 6);      // set and clear together, rewrite cfg (R9, R10)
        run_frame(1, 0, 1, 0, 1, 2, 6, -1, -1);    // trigger on the DONE cycle (R9)

        // Constrained random frames
        for (int f = 0; f < 160; f++) begin
            int l0, l1, l2, l3, dly, n, c, span, inj, clr, scr;
            l0  = $urandom_range(0, 4);
            l1  = $urandom_range(0, 4);
            l2  = $urandom_range(0, 4);
            l3  = $urandom_range(0, 4);
            dly = $urandom_range(0, 12);
            n   = $urandom_range(0, 5);
            c   = l0 + l1 + l2 + l3;
            span = (n == 0) ? 0 : dly + 1 + n * c;
            inj = -1;
            clr = -1;
            scr = -1;
            if (span > 0 && $urandom_range(0, 2) == 0) inj = $urandom_range(1, span);
            if (span > 0 && $urandom_range(0, 3) == 0) clr = $urandom_range(1, span);
            if (span > 0 && $urandom_range(0, 2) == 0) scr = $urandom_range(1, span);
            run_frame(l0, l1, l2, l3, dly, n, inj, clr, scr);
        end
        summary();
    end

endmodule